// File: doc/BRIEF.md
# NAND On-Die ECC Feature Enabler

This block switches the built-in error correction of an attached NAND device on or off. Before any bus activity it checks three bytes taken from the device's parameter page, which an earlier read has already captured. These bytes are the vendor code, the number of correctable bits and the model character. Only a device that passes all three checks receives a set-features transfer. A device that fails any check sees no bus traffic at all.

The host drives a one-cycle start pulse together with an enable/disable choice. When the device qualifies, the block drives a byte-wide NAND bus with one command-latch write, then one address-latch write, then four data writes. Each write has its own strobe that is high for one clock. The block then pulses done. Its supported flag tells the host whether the feature was actually written.

Top module: `nand_ecc_feature_ctl`

## Requirements
- R1: The vendor check passes only when (`vendor_code_i` & 8'h2C) == 8'h2C. Other bits of the byte are don't-care, so 8'hFF and 8'h2D pass and 8'h28 fails.
- R2: The correction check passes only when `ecc_bits_i` is exactly 8'd4. The values 3 and 5 fail.
- R3: The model check passes only when `model_char_i` is ASCII '1' (8'h31), '2' (8'h32) or '4' (8'h34). '3' and the raw value 8'h01 fail.
- R4: For a qualifying device, the writes run on consecutive cycles starting the cycle after start. The first is a command write of 8'hEF on `cmd_we_o`. Next is an address write of 8'h90 on `addr_we_o`. Then come four data writes on `data_we_o`. `done_o` follows in the cycle after the last data write, with `supported_o` = 1.
- R5: The four data bytes are 8'h08, 8'h00, 8'h00, 8'h00 when `ecc_on_i` was 1 at start, and all 8'h00 when it was 0.
- R6: A device that fails any check gets no strobe at all. `done_o` rises in the cycle after start with `supported_o` = 0.
- R7: At most one of the three strobes is high in any cycle, and each strobe-high cycle carries exactly one byte.
- R8: A start pulse that arrives while a transfer or its done cycle is in progress is ignored. The running sequence and its enable choice are unchanged, and no second sequence follows.
- R9: `done_o` is a single-cycle pulse. `supported_o` holds the result of the last request until the next accepted start.
- R10: After reset the block is idle with all strobes, `done_o` and `supported_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| ecc_on_i | input | 1 | 1 = turn on-die correction on, 0 = off; sampled with start |
| vendor_code_i | input | 8 | Vendor byte from the parameter page |
| ecc_bits_i | input | 8 | Correctable-bits byte from the parameter page |
| model_char_i | input | 8 | Model character byte from the parameter page |
| cmd_we_o | output | 1 | Command-latch write strobe |
| addr_we_o | output | 1 | Address-latch write strobe |
| data_we_o | output | 1 | Data write strobe |
| bus_byte_o | output | 8 | Byte carried by the active strobe, 0 otherwise |
| done_o | output | 1 | Completion pulse |
| supported_o | output | 1 | Result of the last request |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a running transfer. That second start also carries the opposite enable choice and a different device profile, so it could corrupt the data bytes or queue a second sequence. The bench fires this pulse during the data beats and again in the done cycle. It then checks that the trace still carries the first request's bytes and that the bus stays quiet afterwards. For the capability check, the vectors cover each field on its own: masked vendor bits, the correction count one above and one below 4, and model characters that sit close to the accepted ones.

// File: rtl/nfe_pkg.sv
// Shared constants and types for the NAND on-die ECC feature enabler.
package nfe_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } seq_state_t;

    localparam byte_t OP_SET_FEATURE = 8'hEF;
    localparam byte_t FEAT_ADDR_ECC  = 8'h90;
    localparam byte_t VENDOR_MASK    = 8'h2C;
    localparam byte_t ECC_BITS_REQ   = 8'd4;
    localparam byte_t ECC_ON_VALUE   = 8'h08;
    localparam int    NUM_MODELS     = 3;
endpackage

// File: rtl/nfe_qualify.sv
// Capability check: decides from three parameter-page bytes whether the
// device supports on-die correction. Purely combinational.
// Assumes the bytes are stable while start is presented.
module nfe_qualify
    import nfe_pkg::*;
#(
    parameter byte_t VENDOR_BITS = VENDOR_MASK,
    parameter byte_t BITS_REQ    = ECC_BITS_REQ,
    parameter byte_t MODEL_LIST [NUM_MODELS] = '{8'h31, 8'h32, 8'h34}
) (
    input  byte_t vendor_code_i,
    input  byte_t ecc_bits_i,
    input  byte_t model_char_i,
    output logic  qualified_o
);
    logic [NUM_MODELS-1:0] model_hit;
    logic                  vendor_ok;
    logic                  bits_ok;

    // One comparator per accepted model character
    for (genvar g = 0; g < NUM_MODELS; g++) begin : g_model
        assign model_hit[g] = (model_char_i == MODEL_LIST[g]);
    end

    // Combine the three field checks
    always_comb begin
        vendor_ok   = ((vendor_code_i & VENDOR_BITS) == VENDOR_BITS);
        bits_ok     = (ecc_bits_i == BITS_REQ);
        qualified_o = vendor_ok && bits_ok && (|model_hit);
    end
endmodule

// File: rtl/nfe_payload.sv
// Data-beat generator: returns the feature data byte for a given beat
// index and enable choice. Assumes beat index is below NUM_DATA.
module nfe_payload
    import nfe_pkg::*;
#(
    parameter int    NUM_DATA  = 4,
    parameter int    ON_BEAT   = 0,
    parameter byte_t ON_VALUE  = ECC_ON_VALUE,
    localparam int   CNT_W     = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
    input  logic             ecc_on_i,
    input  logic [CNT_W-1:0] beat_i,
    output byte_t            data_o
);
    // Only the designated beat carries the enable value
    always_comb begin
        if (ecc_on_i && (beat_i == CNT_W'(ON_BEAT)))
            data_o = ON_VALUE;
        else
            data_o = '0;
    end
endmodule

// File: rtl/nfe_seq.sv
// Sequencer: accepts a start in idle, then either walks command, address
// and NUM_DATA data beats, or jumps straight to done for an unsupported
// device. Starts outside idle are ignored. Outputs decode from state.
module nfe_seq
    import nfe_pkg::*;
#(
    parameter int  NUM_DATA = 4,
    localparam int CNT_W    = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1,
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(NUM_DATA - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ecc_on_i,
    input  logic             qualified_i,
    input  byte_t            payload_i,
    output logic [CNT_W-1:0] beat_o,
    output logic             ecc_on_q_o,
    output logic             cmd_we_o,
    output logic             addr_we_o,
    output logic             data_we_o,
    output byte_t            bus_byte_o,
    output logic             done_o,
    output logic             supported_o
);
    seq_state_t       state;
    logic [CNT_W-1:0] beat;
    logic             ecc_on_q;
    logic             sup_q;

    // State, beat counter and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat     <= '0;
            ecc_on_q <= 1'b0;
            sup_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        ecc_on_q <= ecc_on_i;
                        sup_q    <= qualified_i;
                        beat     <= '0;
                        state    <= qualified_i ? ST_CMD : ST_DONE;
                    end
                end
                ST_CMD:  state <= ST_ADDR;
                ST_ADDR: state <= ST_DATA;
                ST_DATA: begin
                    if (beat == LAST_BEAT) begin
                        state <= ST_DONE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe and byte decode from the current state
    always_comb begin
        cmd_we_o   = (state == ST_CMD);
        addr_we_o  = (state == ST_ADDR);
        data_we_o  = (state == ST_DATA);
        done_o     = (state == ST_DONE);
        bus_byte_o = '0;
        if (cmd_we_o)
            bus_byte_o = OP_SET_FEATURE;
        else if (addr_we_o)
            bus_byte_o = FEAT_ADDR_ECC;
        else if (data_we_o)
            bus_byte_o = payload_i;
    end

    assign beat_o      = beat;
    assign ecc_on_q_o  = ecc_on_q;
    assign supported_o = sup_q;
endmodule

// File: rtl/nand_ecc_feature_ctl.sv
// Top: NAND on-die ECC feature enabler. Checks device capability, then
// writes the set-features sequence over a byte-wide strobed NAND bus.
// Assumes parameter-page bytes are held stable around the start pulse.
module nand_ecc_feature_ctl
    import nfe_pkg::*;
#(
    parameter int  NUM_DATA = 4,
    localparam int CNT_W    = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ecc_on_i,
    input  logic [7:0] vendor_code_i,
    input  logic [7:0] ecc_bits_i,
    input  logic [7:0] model_char_i,
    output logic       cmd_we_o,
    output logic       addr_we_o,
    output logic       data_we_o,
    output logic [7:0] bus_byte_o,
    output logic       done_o,
    output logic       supported_o
);
    logic             qualified;
    logic [CNT_W-1:0] beat;
    logic             ecc_on_q;
    byte_t            payload;

    nfe_qualify u_qualify (
        .vendor_code_i (vendor_code_i),
        .ecc_bits_i    (ecc_bits_i),
        .model_char_i  (model_char_i),
        .qualified_o   (qualified)
    );

    nfe_payload #(.NUM_DATA(NUM_DATA)) u_payload (
        .ecc_on_i (ecc_on_q),
        .beat_i   (beat),
        .data_o   (payload)
    );

    nfe_seq #(.NUM_DATA(NUM_DATA)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ecc_on_i    (ecc_on_i),
        .qualified_i (qualified),
        .payload_i   (payload),
        .beat_o      (beat),
        .ecc_on_q_o  (ecc_on_q),
        .cmd_we_o    (cmd_we_o),
        .addr_we_o   (addr_we_o),
        .data_we_o   (data_we_o),
        .bus_byte_o  (bus_byte_o),
        .done_o      (done_o),
        .supported_o (supported_o)
    );
endmodule

// File: rtl/nand_ecc_feature_chk.sv
// Checker: protocol properties of the enabler's bus and completion ports.
// Assumes synchronous active-low reset; all properties disabled in reset.
module nand_ecc_feature_chk #(
    parameter int NUM_DATA = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we_o,
    input logic       addr_we_o,
    input logic       data_we_o,
    input logic [7:0] bus_byte_o,
    input logic       done_o,
    input logic       supported_o
);
    logic [7:0] data_cnt;

    // Count data beats since the last address write
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_cnt <= '0;
        else if (addr_we_o)
            data_cnt <= '0;
        else if (data_we_o)
            data_cnt <= data_cnt + 8'd1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we_o, addr_we_o, data_we_o})); // R7
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_o |=> !cmd_we_o); // R7
    AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_o |-> bus_byte_o == 8'hEF); // R4
    AST_ADDR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_o |=> (addr_we_o && bus_byte_o == 8'h90)); // R4
    AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we_o |=> data_we_o); // R4
    AST_DATA_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        data_we_o |-> (bus_byte_o == 8'h00 || bus_byte_o == 8'h08)); // R5
    AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && supported_o) |-> (data_cnt == 8'(NUM_DATA))); // R4
    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !supported_o) |-> !$past(cmd_we_o || addr_we_o || data_we_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

bind nand_ecc_feature_ctl nand_ecc_feature_chk #(.NUM_DATA(NUM_DATA)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we_o    (cmd_we_o),
    .addr_we_o   (addr_we_o),
    .data_we_o   (data_we_o),
    .bus_byte_o  (bus_byte_o),
    .done_o      (done_o),
    .supported_o (supported_o)
);

// File: tb/tb_nand_ecc_feature_ctl.sv
module tb_nand_ecc_feature_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ecc_on_i = 1'b0;
    logic [7:0] vendor_code_i = '0;
    logic [7:0] ecc_bits_i = '0;
    logic [7:0] model_char_i = '0;
    logic       cmd_we_o, addr_we_o, data_we_o, done_o, supported_o;
    logic [7:0] bus_byte_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    nand_ecc_feature_ctl dut (.*);

    typedef struct packed {
        logic [7:0] vendor;
        logic [7:0] bits;
        logic [7:0] model;
        logic       en;
        logic       sup;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h2C, 8'd4, 8'h31, 1'b1, 1'b1},  // R1 R2 R3 exact match, enable
        '{8'h2C, 8'd4, 8'h32, 1'b0, 1'b1},  // disable
        '{8'hFF, 8'd4, 8'h34, 1'b1, 1'b1},  // R1 extra vendor bits ignored
        '{8'h2D, 8'd4, 8'h34, 1'b0, 1'b1},  // R1 extra bit
        '{8'h2C, 8'd3, 8'h31, 1'b1, 1'b0},  // R2 below
        '{8'h2C, 8'd5, 8'h32, 1'b1, 1'b0},  // R2 above
        '{8'h28, 8'd4, 8'h31, 1'b1, 1'b0},  // R1 mask bit missing
        '{8'h2C, 8'd4, 8'h33, 1'b1, 1'b0},  // R3 '3'
        '{8'h2C, 8'd4, 8'h01, 1'b0, 1'b0},  // R3 raw 1
        '{8'h0C, 8'd4, 8'h32, 1'b1, 1'b0}   // R1 bit 5 missing
    };

    // Captured trace: kind 1=cmd 2=addr 3=data
    int         tr_n;
    int         tr_kind [16];
    logic [7:0] tr_byte [16];
    logic       tr_sup;
    int         tr_cycles;
    logic       tr_done;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Record bus activity from the cycle after start until done (negedge sampling)
    task automatic capture(input bit busy_poke);
        tr_n = 0; tr_done = 1'b0; tr_cycles = 0; tr_sup = 1'b0;
        for (int c = 0; c < 16 && !tr_done; c++) begin
            tr_cycles++;
            if (int'(cmd_we_o) + int'(addr_we_o) + int'(data_we_o) > 1)
                check(1'b0, "R7", "strobe overlap", 2, 1);
            if (cmd_we_o)  begin tr_kind[tr_n] = 1; tr_byte[tr_n] = bus_byte_o; tr_n++; end
            if (addr_we_o) begin tr_kind[tr_n] = 2; tr_byte[tr_n] = bus_byte_o; tr_n++; end
            if (data_we_o) begin tr_kind[tr_n] = 3; tr_byte[tr_n] = bus_byte_o; tr_n++; end
            if (done_o) begin tr_done = 1'b1; tr_sup = supported_o; end
            // R8: disturb with an opposite, unqualified request mid-run
            if (busy_poke && (c == 3 || done_o)) begin
                start_i = 1'b1; ecc_on_i = ~ecc_on_i; ecc_bits_i = 8'd9;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    task automatic launch(input vec_t v);
        vendor_code_i = v.vendor; ecc_bits_i = v.bits;
        model_char_i = v.model; ecc_on_i = v.en; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_trace(input vec_t v, input string tag);
        check(tr_done == 1'b1, tag, "done seen", int'(tr_done), 1);
        check(tr_sup == v.sup, v.sup ? "R4" : "R6", "supported flag", int'(tr_sup), int'(v.sup));
        if (v.sup) begin
            check(tr_n == 6, "R4", "strobe count", tr_n, 6);
            check(tr_cycles == 7, "R4", "done cycle", tr_cycles, 7);
            if (tr_n == 6) begin
                check(tr_kind[0] == 1 && tr_byte[0] == 8'hEF, "R4", "cmd byte", tr_byte[0], 8'hEF);
                check(tr_kind[1] == 2 && tr_byte[1] == 8'h90, "R4", "addr byte", tr_byte[1], 8'h90);
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] e;
                    e = (k == 0 && v.en) ? 8'h08 : 8'h00;
                    check(tr_kind[2+k] == 3 && tr_byte[2+k] == e, "R5", "data byte",
                          tr_byte[2+k], e);
                end
            end
        end else begin
            check(tr_n == 0, "R6", "no bus traffic", tr_n, 0);
            check(tr_cycles == 1, "R6", "done cycle", tr_cycles, 1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check({cmd_we_o, addr_we_o, data_we_o, done_o, supported_o} == 5'b0,
              "R10", "reset outputs", {cmd_we_o, addr_we_o, data_we_o, done_o, supported_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cmd_we_o, addr_we_o, data_we_o, done_o} == 4'b0, "R10", "idle after reset",
              {cmd_we_o, addr_we_o, data_we_o, done_o}, 0);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i]);
            capture(1'b0);
            check_trace(VECS[i], "R4");
            // R9: done single cycle, flag held
            check(done_o == 1'b0, "R9", "done single pulse", int'(done_o), 0);
            check(supported_o == VECS[i].sup, "R9", "flag held", int'(supported_o), int'(VECS[i].sup));
            repeat (2) @(negedge clk);
        end

        // R8: starts during run and during done are ignored
        launch(VECS[0]);
        capture(1'b1);
        check_trace(VECS[0], "R8");
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 12; c++) begin
                if (cmd_we_o || addr_we_o || data_we_o || done_o) extra++;
                @(negedge clk);
            end
            check(extra == 0, "R8", "no second sequence", extra, 0);
            check(supported_o == 1'b1, "R8", "flag from first request", int'(supported_o), 1);
        end

        // R10: mid-sequence reset returns to idle
        launch(VECS[1]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({cmd_we_o, addr_we_o, data_we_o, done_o, supported_o} == 5'b0,
              "R10", "reset mid-run", {cmd_we_o, addr_we_o, data_we_o, done_o, supported_o}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check({cmd_we_o, addr_we_o, data_we_o, done_o} == 4'b0, "R10", "stays idle",
              {cmd_we_o, addr_we_o, data_we_o, done_o}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule